// File: doc/BRIEF.md
# Accumulator Arithmetic and Logic Unit

This block is the purely combinational datapath of an 8-bit accumulator machine. Each cycle it takes the raw instruction byte, the accumulator, one second operand byte, the B register and the three status flags (carry, auxiliary carry, overflow). It produces the new value of the written byte, the new B register and the new flags. The second operand byte can be a register, a direct byte, an indirect byte or an immediate. Operand fetch, write-back and the register file belong to the surrounding core.

The written byte is the accumulator for most operations. For the memory forms of increment and decrement it is the operand byte plus or minus one. For the memory forms of the logic group it is the operand combined with the accumulator input. For those forms the fetch stage places the immediate on the accumulator input. Any flag that an operation does not define passes through from its input, so the core can always write back all three flags.

Top module: `acc_alu`

## Requirements
- R1: Opcodes 24h–2Fh add the accumulator and operand, and opcodes 34h–3Fh also add the incoming carry. The carry output is the carry out of bit 7, auxiliary carry is the carry out of bit 3, and overflow is the carry into bit 7 XOR the carry out of bit 7.
- R2: Opcodes 94h–9Fh compute accumulator minus operand minus carry. The carry output is the borrow out of bit 7, auxiliary carry is the borrow out of bit 3, and overflow is set when the signed result does not fit in 8 bits.
- R3: Opcode 04h gives accumulator+1 and 05h–0Fh give operand+1. Opcode 14h gives accumulator−1 and 15h–1Fh give operand−1. All four wrap modulo 256 and leave every flag equal to its input.
- R4: Opcode A4h puts the low byte of accumulator×B on the result and the high byte on the B output. It clears carry, and sets overflow exactly when the high byte is non-zero.
- R5: Opcode 84h with non-zero B puts the quotient of accumulator/B on the result and the remainder on the B output, clearing both carry and overflow.
- R6: Opcode 84h with B equal to zero sets overflow, clears carry, drives FFh on the result and the accumulator value on the B output.
- R7: With upper nibble 4h, 5h or 6h and lower nibble 2h–Fh, the result is the bitwise OR, AND or XOR (in that nibble order) of accumulator and operand, and the flags are unchanged.
- R8: E4h gives zero, F4h gives the bitwise inverse of the accumulator, and C4h exchanges the accumulator's two nibbles. None of the three changes a flag.
- R9: 23h rotates the accumulator left by one bit (bit 7 into bit 0) and 03h rotates it right by one bit (bit 0 into bit 7). Carry is unchanged.
- R10: 33h shifts left with carry into bit 0 and bit 7 into carry, and 13h shifts right with carry into bit 7 and bit 0 into carry. Auxiliary carry and overflow are unchanged.
- R11: D4h adds 06h when the low nibble exceeds 9 or auxiliary carry is set. It then adds 60h when the resulting high nibble exceeds 9, carry is set, or the first step carried. Carry is set if either step carried and is never cleared. Auxiliary carry and overflow are unchanged.
- R12: Any opcode not listed above returns the accumulator and all three flags unchanged.
- R13: Every opcode other than A4h and 84h passes B through to the B output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode_i | input | 8 | Instruction byte selecting the operation |
| acc_i | input | DATA_W | Accumulator value |
| opnd_i | input | DATA_W | Second operand byte |
| breg_i | input | DATA_W | B register value |
| cy_i | input | 1 | Incoming carry flag |
| ac_i | input | 1 | Incoming auxiliary carry flag |
| ov_i | input | 1 | Incoming overflow flag |
| res_o | output | DATA_W | Byte to write back |
| breg_o | output | DATA_W | New B register value |
| cy_o | output | 1 | New carry flag |
| ac_o | output | 1 | New auxiliary carry flag |
| ov_o | output | 1 | New overflow flag |

## Verification
The add and subtract paths are tried with operand pairs chosen to separate the flags. One pair carries only out of the low nibble. One overflows only as a signed value. One wraps unsigned without signed overflow. One does both at once. Each pair also runs with the incoming carry high, to expose a carry that is wrongly ignored or wrongly injected. Multiply and divide are tried with and without a high product byte and with a zero divisor. Decimal adjust is tried on values that need no fix, only a low fix, only a high fix, a fix forced by auxiliary carry, and a first-step carry that alone must trigger the second step. Rotates use a value with both end bits set, so that the directions and the carry paths can be told apart.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

   typedef enum logic [4:0] {
      OP_PASS, OP_ADD, OP_ADDC, OP_SUBB,
      OP_INCA, OP_INCM, OP_DECA, OP_DECM,
      OP_MUL, OP_DIV, OP_DA,
      OP_AND, OP_OR, OP_XOR,
      OP_CLR, OP_CPL, OP_SWAP,
      OP_RL, OP_RR, OP_RLC, OP_RRC
   } alu_op_e;

   localparam int OPC_W = 8;

endpackage

// File: rtl/acc_op_decode.sv
module acc_op_decode
   import acc_alu_pkg::*;
(
   input  logic [OPC_W-1:0] opcode_i,
   output alu_op_e          op_o
);

   logic [3:0] hi_nib;
   logic [3:0] lo_nib;

   assign hi_nib = opcode_i[7:4];
   assign lo_nib = opcode_i[3:0];

   always_comb begin
      op_o = OP_PASS;
      case (opcode_i)
         8'h04:   op_o = OP_INCA;
         8'h14:   op_o = OP_DECA;
         8'hA4:   op_o = OP_MUL;
         8'h84:   op_o = OP_DIV;
         8'hD4:   op_o = OP_DA;
         8'hE4:   op_o = OP_CLR;
         8'hF4:   op_o = OP_CPL;
         8'hC4:   op_o = OP_SWAP;
         8'h23:   op_o = OP_RL;
         8'h03:   op_o = OP_RR;
         8'h33:   op_o = OP_RLC;
         8'h13:   op_o = OP_RRC;
         default: begin
            case (hi_nib)
               4'h0: if (lo_nib >= 4'h5) op_o = OP_INCM;
               4'h1: if (lo_nib >= 4'h5) op_o = OP_DECM;
               4'h2: if (lo_nib >= 4'h4) op_o = OP_ADD;
               4'h3: if (lo_nib >= 4'h4) op_o = OP_ADDC;
               4'h9: if (lo_nib >= 4'h4) op_o = OP_SUBB;
               4'h4: if (lo_nib >= 4'h2) op_o = OP_OR;
               4'h5: if (lo_nib >= 4'h2) op_o = OP_AND;
               4'h6: if (lo_nib >= 4'h2) op_o = OP_XOR;
               default: op_o = OP_PASS;
            endcase
         end
      endcase
   end

endmodule

// File: rtl/acc_addsub.sv
module acc_addsub #(
   parameter int DATA_W = 8,
   parameter int NIB_W  = 4
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic              sub_i,
   input  logic              cin_i,
   output logic [DATA_W-1:0] sum_o,
   output logic              cy_o,
   output logic              ac_o,
   output logic              ov_o
);

   logic [DATA_W-1:0] b_eff;
   logic              c_eff;
   logic [NIB_W:0]    low_sum;
   logic [DATA_W-1:0] body_sum;
   logic [DATA_W:0]   full_sum;

   // subtraction as a + ~b + ~borrow; carries are inverted back to borrows
   assign b_eff = sub_i ? ~b_i : b_i;
   assign c_eff = sub_i ? ~cin_i : cin_i;

   assign low_sum  = {1'b0, a_i[NIB_W-1:0]} + {1'b0, b_eff[NIB_W-1:0]}
                   + {{NIB_W{1'b0}}, c_eff};
   assign body_sum = {1'b0, a_i[DATA_W-2:0]} + {1'b0, b_eff[DATA_W-2:0]}
                   + {{(DATA_W-1){1'b0}}, c_eff};
   assign full_sum = {1'b0, a_i} + {1'b0, b_eff} + {{DATA_W{1'b0}}, c_eff};

   assign sum_o = full_sum[DATA_W-1:0];
   assign cy_o  = full_sum[DATA_W] ^ sub_i;
   assign ac_o  = low_sum[NIB_W] ^ sub_i;
   assign ov_o  = body_sum[DATA_W-1] ^ full_sum[DATA_W];

endmodule

// File: rtl/acc_muldiv.sv
module acc_muldiv #(
   parameter int DATA_W    = 8,
   parameter int DIV_STYLE = 0
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   output logic [DATA_W-1:0] prod_lo_o,
   output logic [DATA_W-1:0] prod_hi_o,
   output logic [DATA_W-1:0] quo_o,
   output logic [DATA_W-1:0] rem_o
);

   localparam int PROD_W = 2 * DATA_W;

   logic [PROD_W-1:0] prod;

   assign prod      = {{DATA_W{1'b0}}, a_i} * {{DATA_W{1'b0}}, b_i};
   assign prod_lo_o = prod[DATA_W-1:0];
   assign prod_hi_o = prod[PROD_W-1:DATA_W];

   generate
      if (DIV_STYLE == 0) begin : g_div_array
         // restoring array; a zero divisor naturally yields all-ones and a
         always_comb begin
            logic [DATA_W:0] part;
            part  = '0;
            quo_o = '0;
            for (int i = DATA_W - 1; i >= 0; i--) begin
               part = {part[DATA_W-1:0], a_i[i]};
               if (part >= {1'b0, b_i}) begin
                  part     = part - {1'b0, b_i};
                  quo_o[i] = 1'b1;
               end
            end
            rem_o = part[DATA_W-1:0];
         end
      end else if (DIV_STYLE == 1) begin : g_div_operator
         always_comb begin
            if (b_i == '0) begin
               quo_o = '1;
               rem_o = a_i;
            end else begin
               quo_o = a_i / b_i;
               rem_o = a_i % b_i;
            end
         end
      end else begin : g_div_bad
         $error("acc_muldiv: DIV_STYLE must be 0 or 1");
      end
   endgenerate

endmodule

// File: rtl/acc_bitops.sv
module acc_bitops
   import acc_alu_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  alu_op_e           op_i,
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic              cy_i,
   output logic [DATA_W-1:0] res_o,
   output logic              cy_o
);

   localparam int HALF_W = DATA_W / 2;

   always_comb begin
      res_o = a_i;
      cy_o  = cy_i;
      case (op_i)
         OP_AND:  res_o = a_i & b_i;
         OP_OR:   res_o = a_i | b_i;
         OP_XOR:  res_o = a_i ^ b_i;
         OP_CLR:  res_o = '0;
         OP_CPL:  res_o = ~a_i;
         OP_SWAP: res_o = {a_i[HALF_W-1:0], a_i[DATA_W-1:HALF_W]};
         OP_RL:   res_o = {a_i[DATA_W-2:0], a_i[DATA_W-1]};
         OP_RR:   res_o = {a_i[0], a_i[DATA_W-1:1]};
         OP_RLC: begin
            res_o = {a_i[DATA_W-2:0], cy_i};
            cy_o  = a_i[DATA_W-1];
         end
         OP_RRC: begin
            res_o = {cy_i, a_i[DATA_W-1:1]};
            cy_o  = a_i[0];
         end
         default: begin
            res_o = a_i;
            cy_o  = cy_i;
         end
      endcase
   end

endmodule

// File: rtl/acc_decadj.sv
module acc_decadj #(
   parameter int DATA_W = 8,
   parameter int NIB_W  = 4
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic              cy_i,
   input  logic              ac_i,
   output logic [DATA_W-1:0] res_o,
   output logic              cy_o
);

   localparam logic [DATA_W:0]  FIX_LO = (DATA_W+1)'(6);
   localparam logic [DATA_W:0]  FIX_HI = (DATA_W+1)'(96);
   localparam logic [NIB_W-1:0] DIG_MAX = NIB_W'(9);

   logic            need_lo;
   logic            need_hi;
   logic [DATA_W:0] step1;
   logic [DATA_W:0] step2;

   assign need_lo = (a_i[NIB_W-1:0] > DIG_MAX) || ac_i;
   assign step1   = {1'b0, a_i} + (need_lo ? FIX_LO : '0);
   assign need_hi = (step1[DATA_W-1:NIB_W] > DIG_MAX) || cy_i || step1[DATA_W];
   assign step2   = {1'b0, step1[DATA_W-1:0]} + (need_hi ? FIX_HI : '0);

   assign res_o = step2[DATA_W-1:0];
   assign cy_o  = cy_i | step1[DATA_W] | step2[DATA_W];

endmodule

// File: rtl/acc_alu.sv
module acc_alu
   import acc_alu_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int DIV_STYLE = 0
) (
   input  logic [7:0]        opcode_i,
   input  logic [DATA_W-1:0] acc_i,
   input  logic [DATA_W-1:0] opnd_i,
   input  logic [DATA_W-1:0] breg_i,
   input  logic              cy_i,
   input  logic              ac_i,
   input  logic              ov_i,
   output logic [DATA_W-1:0] res_o,
   output logic [DATA_W-1:0] breg_o,
   output logic              cy_o,
   output logic              ac_o,
   output logic              ov_o
);

   localparam int NIB_W = DATA_W / 2;
   localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

   generate
      if (DATA_W != 8) begin : g_bad_width
         $error("acc_alu: decimal adjust and opcode map need DATA_W == 8");
      end
   endgenerate

   alu_op_e           op;
   logic [DATA_W-1:0] as_sum;
   logic              as_cy, as_ac, as_ov;
   logic [DATA_W-1:0] p_lo, p_hi, q, r;
   logic [DATA_W-1:0] bit_res;
   logic              bit_cy;
   logic [DATA_W-1:0] da_res;
   logic              da_cy;
   logic              is_sub;
   logic              cin_eff;

   assign is_sub  = (op == OP_SUBB);
   assign cin_eff = (op == OP_ADD) ? 1'b0 : cy_i;

   acc_op_decode u_dec (
      .opcode_i (opcode_i),
      .op_o     (op)
   );

   acc_addsub #(.DATA_W(DATA_W), .NIB_W(NIB_W)) u_addsub (
      .a_i   (acc_i),
      .b_i   (opnd_i),
      .sub_i (is_sub),
      .cin_i (cin_eff),
      .sum_o (as_sum),
      .cy_o  (as_cy),
      .ac_o  (as_ac),
      .ov_o  (as_ov)
   );

   acc_muldiv #(.DATA_W(DATA_W), .DIV_STYLE(DIV_STYLE)) u_muldiv (
      .a_i       (acc_i),
      .b_i       (breg_i),
      .prod_lo_o (p_lo),
      .prod_hi_o (p_hi),
      .quo_o     (q),
      .rem_o     (r)
   );

   acc_bitops #(.DATA_W(DATA_W)) u_bitops (
      .op_i  (op),
      .a_i   (acc_i),
      .b_i   (opnd_i),
      .cy_i  (cy_i),
      .res_o (bit_res),
      .cy_o  (bit_cy)
   );

   acc_decadj #(.DATA_W(DATA_W), .NIB_W(NIB_W)) u_da (
      .a_i   (acc_i),
      .cy_i  (cy_i),
      .ac_i  (ac_i),
      .res_o (da_res),
      .cy_o  (da_cy)
   );

   always_comb begin
      res_o  = acc_i;
      breg_o = breg_i;
      cy_o   = cy_i;
      ac_o   = ac_i;
      ov_o   = ov_i;
      case (op)
         OP_ADD, OP_ADDC, OP_SUBB: begin
            res_o = as_sum;
            cy_o  = as_cy;
            ac_o  = as_ac;
            ov_o  = as_ov;
         end
         OP_INCA: res_o = acc_i + ONE;
         OP_INCM: res_o = opnd_i + ONE;
         OP_DECA: res_o = acc_i - ONE;
         OP_DECM: res_o = opnd_i - ONE;
         OP_MUL: begin
            res_o  = p_lo;
            breg_o = p_hi;
            cy_o   = 1'b0;
            ov_o   = |p_hi;
         end
         OP_DIV: begin
            res_o  = q;
            breg_o = r;
            cy_o   = 1'b0;
            ov_o   = (breg_i == '0);
         end
         OP_DA: begin
            res_o = da_res;
            cy_o  = da_cy;
         end
         OP_AND, OP_OR, OP_XOR, OP_CLR, OP_CPL, OP_SWAP,
         OP_RL, OP_RR, OP_RLC, OP_RRC: begin
            res_o = bit_res;
            cy_o  = bit_cy;
         end
         default: begin
            res_o = acc_i;
         end
      endcase
   end

endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk #(
   parameter int DATA_W = 8
) (
   input logic [7:0]        opcode_i,
   input logic [DATA_W-1:0] acc_i,
   input logic [DATA_W-1:0] opnd_i,
   input logic [DATA_W-1:0] breg_i,
   input logic              cy_i,
   input logic              ac_i,
   input logic              ov_i,
   input logic [DATA_W-1:0] res_o,
   input logic [DATA_W-1:0] breg_o,
   input logic              cy_o,
   input logic              ac_o,
   input logic              ov_o
);

   localparam int W2 = 2 * DATA_W;

   logic          is_add, is_incdec, is_rot;
   logic [W2-1:0] prod_ref, prod_out, div_back;
   logic [DATA_W:0] add_ref;

   assign is_add    = (opcode_i[7:4] == 4'h2) && (opcode_i[3:0] >= 4'h4);
   assign is_incdec = (opcode_i[7:5] == 3'b000) && (opcode_i[3:0] >= 4'h4);
   assign is_rot    = (opcode_i == 8'h23) || (opcode_i == 8'h03);
   assign add_ref   = {1'b0, acc_i} + {1'b0, opnd_i};
   assign prod_ref  = {{DATA_W{1'b0}}, acc_i} * {{DATA_W{1'b0}}, breg_i};
   assign prod_out  = {breg_o, res_o};
   assign div_back  = {{DATA_W{1'b0}}, res_o} * {{DATA_W{1'b0}}, breg_i}
                    + {{DATA_W{1'b0}}, breg_o};

   always_comb begin
      if (is_add)
         a_r1_add_sum: assert ({cy_o, res_o} == add_ref);
      if (is_incdec)
         a_r3_flags_kept: assert (cy_o == cy_i && ac_o == ac_i && ov_o == ov_i);
      if (opcode_i == 8'hA4)
         a_r4_mul_split: assert (prod_out == prod_ref && !cy_o);
      if (opcode_i == 8'h84 && breg_i != '0)
         a_r5_div_identity: assert (div_back == {{DATA_W{1'b0}}, acc_i}
                                    && breg_o < breg_i && !ov_o && !cy_o);
      if (opcode_i == 8'h84 && breg_i == '0)
         a_r6_divzero_flag: assert (ov_o && !cy_o);
      if (is_rot)
         a_r9_rot_keeps_carry: assert (cy_o == cy_i
                                       && $countones(res_o) == $countones(acc_i));
      if (opcode_i != 8'hA4 && opcode_i != 8'h84)
         a_r13_b_through: assert (breg_o == breg_i);
   end

endmodule

bind acc_alu acc_alu_chk #(.DATA_W(DATA_W)) u_acc_alu_chk (
   .opcode_i (opcode_i),
   .acc_i    (acc_i),
   .opnd_i   (opnd_i),
   .breg_i   (breg_i),
   .cy_i     (cy_i),
   .ac_i     (ac_i),
   .ov_i     (ov_i),
   .res_o    (res_o),
   .breg_o   (breg_o),
   .cy_o     (cy_o),
   .ac_o     (ac_o),
   .ov_o     (ov_o)
);

// File: tb/test_acc_alu.sv
module test_acc_alu;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] opc, acc, opnd, breg;
   logic       cy, ac, ov;
   logic [7:0] res, bout;
   logic       cyo, aco, ovo;
   int         n_chk = 0;
   int         n_bad = 0;

   always #4 clk = ~clk;

   acc_alu i_acc_alu (
      .opcode_i (opc),
      .acc_i    (acc),
      .opnd_i   (opnd),
      .breg_i   (breg),
      .cy_i     (cy),
      .ac_i     (ac),
      .ov_i     (ov),
      .res_o    (res),
      .breg_o   (bout),
      .cy_o     (cyo),
      .ac_o     (aco),
      .ov_o     (ovo)
   );

   task automatic drive(input logic [7:0] o, input logic [7:0] a, input logic [7:0] d,
                        input logic [7:0] b, input logic c, input logic x, input logic v);
      @(negedge clk);
      opc = o; acc = a; opnd = d; breg = b; cy = c; ac = x; ov = v;
      #1;
   endtask

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic t_reset;
      drive(8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0);
      check("R12 idle outputs", {res, bout}, 16'h0000);
      check("R12 idle flags", {13'd0, cyo, aco, ovo}, 16'd0);
   endtask

   task automatic t_arith(input logic [7:0] o, input logic [7:0] a, input logic [7:0] d,
                          input logic cin);
      int ci, full, r8;
      logic ec, eac, eov;
      logic [7:0] er;
      ci = (o[7:4] == 4'h2) ? 0 : int'(cin);
      if (o[7:4] == 4'h9) begin
         full = int'(a) - int'(d) - ci;
         ec   = full < 0;
         eac  = int'(a[3:0]) < int'(d[3:0]) + ci;
         r8   = full & 255;
         er   = r8[7:0];
         eov  = (a[7] != d[7]) && (er[7] != a[7]);
      end else begin
         full = int'(a) + int'(d) + ci;
         ec   = full > 255;
         eac  = int'(a[3:0]) + int'(d[3:0]) + ci > 15;
         r8   = full & 255;
         er   = r8[7:0];
         eov  = (a[7] == d[7]) && (er[7] != a[7]);
      end
      drive(o, a, d, 8'h5A, cin, ~eac, ~eov);
      if (o[7:4] == 4'h9) begin
         check("R2 subb result", {8'h00, res}, {8'h00, er});
         check("R2 subb flags", {13'd0, cyo, aco, ovo}, {13'd0, ec, eac, eov});
      end else begin
         check("R1 add result", {8'h00, res}, {8'h00, er});
         check("R1 add flags", {13'd0, cyo, aco, ovo}, {13'd0, ec, eac, eov});
      end
   endtask

   task automatic t_incdec;
      drive(8'h04, 8'hFF, 8'h10, 8'h00, 1'b1, 1'b0, 1'b1);
      check("R3 inc acc wrap", {8'h00, res}, 16'h0000);
      check("R3 inc flags", {13'd0, cyo, aco, ovo}, 16'd5);
      drive(8'h06, 8'h11, 8'h7F, 8'h00, 1'b0, 1'b1, 1'b0);
      check("R3 inc operand", {8'h00, res}, 16'h0080);
      drive(8'h14, 8'h00, 8'h22, 8'h00, 1'b0, 1'b0, 1'b0);
      check("R3 dec acc wrap", {8'h00, res}, 16'h00FF);
      check("R3 dec flags", {13'd0, cyo, aco, ovo}, 16'd0);
      drive(8'h1F, 8'h33, 8'h01, 8'h00, 1'b1, 1'b1, 1'b1);
      check("R3 dec operand", {8'h00, res}, 16'h0000);
      check("R3 dec flags kept", {13'd0, cyo, aco, ovo}, 16'd7);
   endtask

   task automatic t_mul;
      drive(8'hA4, 8'h80, 8'h00, 8'h04, 1'b1, 1'b0, 1'b0);
      check("R4 mul high", {bout, res}, 16'h0200);
      check("R4 mul flags", {13'd0, cyo, aco, ovo}, 16'd1);
      drive(8'hA4, 8'h0F, 8'h00, 8'h0F, 1'b1, 1'b1, 1'b1);
      check("R4 mul small", {bout, res}, 16'h00E1);
      check("R4 mul small flags", {13'd0, cyo, aco, ovo}, 16'd2);
   endtask

   task automatic t_div;
      drive(8'h84, 8'hC8, 8'h00, 8'h07, 1'b1, 1'b0, 1'b1);
      check("R5 div q r", {bout, res}, 16'h041C);
      check("R5 div flags", {13'd0, cyo, aco, ovo}, 16'd0);
      drive(8'h84, 8'h05, 8'h00, 8'h09, 1'b0, 1'b0, 1'b0);
      check("R5 div small", {bout, res}, 16'h0500);
      drive(8'h84, 8'h37, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0);
      check("R6 divzero values", {bout, res}, 16'h37FF);
      check("R6 divzero flags", {13'd0, cyo, aco, ovo}, 16'd1);
   endtask

   task automatic t_logic;
      drive(8'h48, 8'hF0, 8'h0C, 8'h11, 1'b1, 1'b0, 1'b1);
      check("R7 or", {8'h00, res}, 16'h00FC);
      check("R7 flags", {13'd0, cyo, aco, ovo}, 16'd5);
      drive(8'h55, 8'hF0, 8'h3C, 8'h11, 1'b0, 1'b1, 1'b0);
      check("R7 and", {8'h00, res}, 16'h0030);
      drive(8'h63, 8'hF0, 8'h3C, 8'h11, 1'b0, 1'b0, 1'b0);
      check("R7 xor", {8'h00, res}, 16'h00CC);
      check("R13 b kept", {8'h00, bout}, 16'h0011);
      drive(8'h42, 8'h01, 8'h80, 8'h11, 1'b0, 1'b0, 1'b0);
      check("R7 or memory form", {8'h00, res}, 16'h0081);
   endtask

   task automatic t_misc;
      drive(8'hE4, 8'hA5, 8'h00, 8'h00, 1'b1, 1'b1, 1'b1);
      check("R8 clr", {8'h00, res}, 16'h0000);
      check("R8 flags", {13'd0, cyo, aco, ovo}, 16'd7);
      drive(8'hF4, 8'hA5, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0);
      check("R8 cpl", {8'h00, res}, 16'h005A);
      drive(8'hC4, 8'h3E, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0);
      check("R8 swap", {8'h00, res}, 16'h00E3);
   endtask

   task automatic t_rot;
      drive(8'h23, 8'h81, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0);
      check("R9 rl", {8'h00, res}, 16'h0003);
      check("R9 rl carry", {15'd0, cyo}, 16'd0);
      drive(8'h03, 8'h81, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0);
      check("R9 rr", {8'h00, res}, 16'h00C0);
      check("R9 rr carry", {15'd0, cyo}, 16'd1);
      drive(8'h33, 8'h81, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0);
      check("R10 rlc", {8'h00, res}, 16'h0002);
      check("R10 rlc flags", {13'd0, cyo, aco, ovo}, 16'd6);
      drive(8'h13, 8'h81, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1);
      check("R10 rrc", {8'h00, res}, 16'h0040);
      check("R10 rrc flags", {13'd0, cyo, aco, ovo}, 16'd5);
      drive(8'h13, 8'h02, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0);
      check("R10 rrc carry in", {7'd0, cyo, res}, 16'h0081);
   endtask

   task automatic t_da;
      drive(8'hD4, 8'h45, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1);
      check("R11 da none", {7'd0, cyo, res}, 16'h0045);
      check("R11 da ov kept", {15'd0, ovo}, 16'd1);
      drive(8'hD4, 8'h9A, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0);
      check("R11 da both", {7'd0, cyo, res}, 16'h0100);
      drive(8'hD4, 8'h15, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0);
      check("R11 da by ac", {7'd0, cyo, res}, 16'h001B);
      check("R11 da ac kept", {15'd0, aco}, 16'd1);
      drive(8'hD4, 8'h08, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0);
      check("R11 da by carry", {7'd0, cyo, res}, 16'h0168);
      drive(8'hD4, 8'hFA, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0);
      check("R11 da first step carry", {7'd0, cyo, res}, 16'h0160);
      drive(8'hD4, 8'hB2, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0);
      check("R11 da high only", {7'd0, cyo, res}, 16'h0112);
   endtask

   task automatic t_other;
      drive(8'h22, 8'h6B, 8'hFF, 8'h44, 1'b1, 1'b0, 1'b1);
      check("R12 unlisted result", {8'h00, res}, 16'h006B);
      check("R12 unlisted flags", {13'd0, cyo, aco, ovo}, 16'd5);
      check("R13 b unlisted", {8'h00, bout}, 16'h0044);
      drive(8'h74, 8'h6B, 8'hFF, 8'h44, 1'b0, 1'b1, 1'b0);
      check("R12 move immediate untouched", {8'h00, res}, 16'h006B);
      drive(8'h41, 8'h6B, 8'hFF, 8'h44, 1'b0, 1'b0, 1'b0);
      check("R12 logic nibble 1 untouched", {8'h00, res}, 16'h006B);
   endtask

   initial begin
      #(8 * 200000);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      opc = 8'h00; acc = 8'h00; opnd = 8'h00; breg = 8'h00;
      cy = 1'b0; ac = 1'b0; ov = 1'b0;
      repeat (4) @(posedge clk);
      rst_n = 1'b1;
      t_reset;
      t_arith(8'h28, 8'h0F, 8'h01, 1'b0);
      t_arith(8'h24, 8'h7F, 8'h01, 1'b1);
      t_arith(8'h25, 8'hFF, 8'h01, 1'b0);
      t_arith(8'h26, 8'h80, 8'h80, 1'b0);
      t_arith(8'h38, 8'h3C, 8'h43, 1'b1);
      t_arith(8'h34, 8'h7F, 8'h00, 1'b1);
      t_arith(8'h3F, 8'h7E, 8'h00, 1'b0);
      t_arith(8'h98, 8'h10, 8'h01, 1'b0);
      t_arith(8'h94, 8'h80, 8'h01, 1'b0);
      t_arith(8'h95, 8'h00, 8'h01, 1'b1);
      t_arith(8'h9F, 8'h7F, 8'hFF, 1'b0);
      t_arith(8'h96, 8'h55, 8'h55, 1'b1);
      t_incdec;
      t_mul;
      t_div;
      t_logic;
      t_misc;
      t_rot;
      t_da;
      t_other;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule